// File: doc/BRIEF.md
# Asynchronous Serial Receive Controller

This block turns asynchronous serial frames arriving on one input line into parallel words. It runs on the system clock and takes a one-cycle sampling strobe from an external rate source at sixteen strobes per bit. The line first passes through a synchronizer. A start detector then looks for a falling edge and confirms it at the middle of the start bit. After that, seven, eight or nine data bits are shifted in least significant bit first. An optional parity bit and one stop bit follow.

When a frame completes, the low data bits go to an 8-bit result register. A separate one-bit holding flag takes either the ninth data bit or the received parity bit. Framing and parity error flags are updated for that frame, and an interrupt is raised. The interrupt stays high until the consumer pulses a read acknowledge. A frame that completes while the previous one is still unacknowledged sets an overrun flag.

The receive sequencer has six states. `ST_IDLE` waits for a low line on a strobe and moves to `ST_START`. `ST_START` counts to mid-bit: it returns to `ST_IDLE` if the line is high again, otherwise it enters `ST_DATA`. `ST_DATA` samples one bit every sixteen strobes. After the last data bit it moves to `ST_PARITY` when parity is active, or straight to `ST_STOP`. `ST_PARITY` samples one bit and moves to `ST_STOP`. `ST_STOP` samples the stop bit and completes the frame. It goes to `ST_IDLE` on a high stop bit, or to `ST_HOLD` on a low one. `ST_HOLD` waits for the line to go high and then returns to `ST_IDLE`.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset, rx_data, rx_bit9, rx_irq, err_frame, err_parity and err_overrun are all 0.
- R2: A frame is one low start bit, the data bits least significant first, an optional parity bit and one stop bit, each sixteen strobes long. The data word appears on rx_data in the cycle after the stop bit is sampled. rx_data does not change at any other time.
- R3: A low pulse that has ended before the middle of the start bit (eight strobes after it is seen) is discarded and changes no output.
- R4: With len_sel = 2'b00 the frame carries 7 data bits, which land in rx_data[6:0]. rx_data[7] carries no meaning in this mode.
- R5: With len_sel = 2'b10 the frame carries 9 data bits. Bits 0 to 7 land in rx_data and the ninth bit lands in rx_bit9. par_en has no effect in this mode, no parity bit is expected and err_parity reads 0. len_sel = 2'b01 or 2'b11 selects 8 data bits.
- R6: With par_en = 1 in 7- or 8-bit mode, the bit after the data is taken as parity and stored in rx_bit9.
- R7: err_parity is set for a frame whose parity bit fails the selected check and cleared for one that passes. The check is even (data ones plus parity bit even) when par_odd = 0 and odd when par_odd = 1.
- R8: err_frame takes the inverse of the sampled stop bit on every frame. After a low stop bit the receiver ignores the line until it has gone high again.
- R9: rx_irq rises in the cycle after a frame completes and stays high until a cycle with rd_ack = 1 and no completion. rx_irq falls in the cycle after that cycle.
- R10: A frame that completes while rx_irq is high and rd_ack is low sets err_overrun and replaces the data. err_overrun is cleared together with rx_irq by rd_ack.
- R11: In 7- or 8-bit mode with par_en = 0, rx_bit9 reads 0 after each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling strobe, sixteen per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Data length: 00 seven, 01 eight, 10 nine, 11 eight |
| par_en | input | 1 | Expect a parity bit in 7- or 8-bit mode |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_ack | input | 1 | One-cycle pulse: the consumer has taken the word |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit9 | output | 1 | Ninth data bit or received parity bit |
| rx_irq | output | 1 | Receive-complete interrupt |
| err_frame | output | 1 | Stop bit of the last frame was low |
| err_parity | output | 1 | Parity of the last frame failed |
| err_overrun | output | 1 | A frame arrived before the previous one was acknowledged |

## Verification
The hardest case to reach from the ports is the stretch after a framing error while the line is still held low. Only a receiver that waits for the line to recover stays silent there; one that returns to idle at once decodes a phantom frame. The stimulus holds the stop bit low and then keeps the line low for another half bit. It then sends a clean frame, and the per-clock reference model expects exactly one completion with the new word. The model derives every completion instant from its own strobe count: ten strobes after the edge is driven for the start check, plus sixteen per following bit. A false start or a missed one therefore shows up in the exact cycle it happens. Other cases covered this way are a start glitch that must vanish and two unacknowledged frames in a row.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    localparam logic [1:0] LEN_SEVEN = 2'b00;
    localparam logic [1:0] LEN_EIGHT = 2'b01;
    localparam logic [1:0] LEN_NINE  = 2'b10;

    // Number of data bits carried by a frame for a given length code.
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        case (code)
            LEN_SEVEN: data_bits = 4'd7;
            LEN_NINE:  data_bits = 4'd9;
            default:   data_bits = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe_q;

    // Reset to the idle line level so no false start follows reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_MAX   = 9,
    parameter int BC_W       = $clog2(DATA_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rx,
    input  logic [BC_W-1:0]     nbits,
    input  logic                par_on,
    output logic                done,
    output logic                stop_lvl,
    output logic                par_bit,
    output logic [DATA_MAX-1:0] word,
    output rx_state_t           state_o
);

    localparam int OS_W = $clog2(OVERSAMPLE);
    localparam logic [OS_W-1:0] MID_CNT  = OS_W'(OVERSAMPLE / 2 - 1);
    localparam logic [OS_W-1:0] LAST_CNT = OS_W'(OVERSAMPLE - 1);

    rx_state_t           state_q, state_d;
    logic [OS_W-1:0]     os_q;
    logic [BC_W-1:0]     bc_q;
    logic [DATA_MAX-1:0] sh_q;
    logic                pb_q;
    logic                at_mid;
    logic                last_bit;
    logic                take_data;
    logic                take_par;
    logic                counting;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !rx) state_d = ST_START;
            ST_START:  if (at_mid) state_d = rx ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_mid && last_bit) state_d = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_mid) state_d = ST_STOP;
            ST_STOP:   if (at_mid) state_d = rx ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (rx) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Decoded outputs of the sequencer.
    always_comb begin
        counting  = (state_q == ST_START) || (state_q == ST_DATA) ||
                    (state_q == ST_PARITY) || (state_q == ST_STOP);
        at_mid    = tick && ((state_q == ST_START) ? (os_q == MID_CNT) : (os_q == LAST_CNT));
        last_bit  = (bc_q == nbits - 1'b1);
        take_data = (state_q == ST_DATA) && at_mid;
        take_par  = (state_q == ST_PARITY) && at_mid;
        done      = (state_q == ST_STOP) && at_mid;
        stop_lvl  = rx;
        par_bit   = pb_q;
        word      = sh_q >> (BC_W'(DATA_MAX) - nbits);
        state_o   = state_q;
    end

    // Strobe counter, bit counter and shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
            bc_q <= '0;
            sh_q <= '0;
            pb_q <= 1'b0;
        end else begin
            if ((state_q != state_d) || at_mid) begin
                os_q <= '0;
            end else if (tick && counting) begin
                os_q <= os_q + 1'b1;
            end

            if (state_q == ST_START) begin
                bc_q <= '0;
            end else if (take_data) begin
                bc_q <= bc_q + 1'b1;
            end

            if (take_data) begin
                sh_q <= {rx, sh_q[DATA_MAX-1:1]};
            end

            if (take_par) begin
                pb_q <= rx;
            end
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
    parameter int DATA_MAX = 9,
    parameter int BC_W     = $clog2(DATA_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [DATA_MAX-1:0] word,
    input  logic [BC_W-1:0]     nbits,
    input  logic                par_on,
    input  logic                par_odd,
    input  logic                par_bit,
    input  logic                stop_lvl,
    input  logic                rd_ack,
    output logic [DATA_MAX-2:0] data_o,
    output logic                bit9_o,
    output logic                irq_o,
    output logic                fe_o,
    output logic                pe_o,
    output logic                ovr_o
);

    logic ones_odd;
    logic par_bad;
    logic ninth;

    // Parity over the received data bits only.
    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (BC_W'(i) < nbits) begin
                ones_odd = ones_odd ^ word[i];
            end
        end
        par_bad = par_on && ((ones_odd ^ par_bit) != par_odd);
        if (nbits == BC_W'(DATA_MAX)) begin
            ninth = word[DATA_MAX-1];
        end else begin
            ninth = par_on ? par_bit : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            bit9_o <= 1'b0;
            irq_o  <= 1'b0;
            fe_o   <= 1'b0;
            pe_o   <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (done) begin
            data_o <= word[DATA_MAX-2:0];
            bit9_o <= ninth;
            fe_o   <= !stop_lvl;
            pe_o   <= par_bad;
            irq_o  <= 1'b1;
            ovr_o  <= irq_o && !rd_ack;
        end else if (rd_ack) begin
            irq_o <= 1'b0;
            ovr_o <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_irq,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);

    localparam int DATA_MAX = 9;
    localparam int BC_W     = $clog2(DATA_MAX + 1);

    logic                rx_s;
    logic [BC_W-1:0]     nbits;
    logic                par_on;
    logic                frame_done;
    logic                stop_lvl;
    logic                par_bit;
    logic [DATA_MAX-1:0] word;
    rx_state_t           rx_state;

    assign nbits  = BC_W'(data_bits(len_sel));
    assign par_on = par_en && (len_sel != LEN_NINE);

    uart_rx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    uart_rx_frame #(
        .OVERSAMPLE (OVERSAMPLE),
        .DATA_MAX   (DATA_MAX),
        .BC_W       (BC_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx       (rx_s),
        .nbits    (nbits),
        .par_on   (par_on),
        .done     (frame_done),
        .stop_lvl (stop_lvl),
        .par_bit  (par_bit),
        .word     (word),
        .state_o  (rx_state)
    );

    uart_rx_status #(
        .DATA_MAX (DATA_MAX),
        .BC_W     (BC_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (frame_done),
        .word     (word),
        .nbits    (nbits),
        .par_on   (par_on),
        .par_odd  (par_odd),
        .par_bit  (par_bit),
        .stop_lvl (stop_lvl),
        .rd_ack   (rd_ack),
        .data_o   (rx_data),
        .bit9_o   (rx_bit9),
        .irq_o    (rx_irq),
        .fe_o     (err_frame),
        .pe_o     (err_parity),
        .ovr_o    (err_overrun)
    );

endmodule

// File: rtl/uart_rx_ctrl_chk.sv
module uart_rx_ctrl_chk
    import uart_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       rx_s,
    input logic [1:0] len_sel,
    input logic       rd_ack,
    input logic [7:0] rx_data,
    input logic       rx_irq,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun,
    input rx_state_t  state
);

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_irq); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !done) |=> (!rx_irq && !err_overrun)); // R9

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(done)); // R9

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_irq && !rd_ack) |=> err_overrun); // R10

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_data)); // R2

    AST_NINE_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (len_sel == 2'b10)) |=> !err_parity); // R5

    AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (err_frame == !$past(rx_s))); // R8

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && !rx_s) |=> (state == ST_HOLD)); // R8

endmodule

bind uart_rx_ctrl uart_rx_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (frame_done),
    .rx_s        (rx_s),
    .len_sel     (len_sel),
    .rd_ack      (rd_ack),
    .rx_data     (rx_data),
    .rx_irq      (rx_irq),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .state       (rx_state)
);

// File: tb/uart_rx_ctrl_tb.sv
module uart_rx_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'b01;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_irq, err_frame, err_parity, err_overrun;

    always #10 clk = ~clk;

    uart_rx_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .rxd (rxd),
        .len_sel (len_sel), .par_en (par_en), .par_odd (par_odd), .rd_ack (rd_ack),
        .rx_data (rx_data), .rx_bit9 (rx_bit9), .rx_irq (rx_irq),
        .err_frame (err_frame), .err_parity (err_parity), .err_overrun (err_overrun)
    );

    typedef struct {
        logic [7:0] data;
        logic [7:0] mask;
        logic       b9, fe, pe;
        int         nb;
        string      tag;
    } exp_t;

    typedef struct {
        logic lvl;
        bit   first;
    } unit_t;

    int    checks = 0, errors = 0;
    int    cyc = 0, gtick = 0, phase = 0, ustart = 0;
    bit    active = 0, pend = 0, ack_req = 0, ack_on = 0, finished = 0;
    int    pend_tick = 0;
    exp_t  pend_e;
    exp_t  frm_q[$];
    unit_t unit_q[$];

    logic [7:0] e_data = 8'h00, e_mask = 8'hFF;
    logic       e_b9 = 0, e_fe = 0, e_pe = 0, e_irq = 0, e_ovr = 0;
    string      e_tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, expv, cyc);
        end
    endtask

    // Line driver, strobe generator and per-clock reference comparison.
    initial begin
        unit_t u;
        forever begin
            @(negedge clk);
            cyc++;
            if (tick) gtick++;
            if (ack_on) begin
                rd_ack = 1'b0;
                ack_on = 0;
                e_irq  = 1'b0;
                e_ovr  = 1'b0;
            end
            if (tick && pend && (gtick == pend_tick)) begin
                e_ovr  = e_irq;
                e_irq  = 1'b1;
                e_data = pend_e.data;
                e_mask = pend_e.mask;
                e_b9   = pend_e.b9;
                e_fe   = pend_e.fe;
                e_pe   = pend_e.pe;
                e_tag  = pend_e.tag;
                pend   = 0;
            end
            if (rst_n && !finished) begin
                chk((rx_data & e_mask) == (e_data & e_mask), e_tag, "rx_data", 16'(rx_data & e_mask), 16'(e_data & e_mask));
                chk(rx_bit9 == e_b9, e_tag, "rx_bit9", 16'(rx_bit9), 16'(e_b9));
                chk(err_frame == e_fe, "R8", "err_frame", 16'(err_frame), 16'(e_fe));
                chk(err_parity == e_pe, "R7", "err_parity", 16'(err_parity), 16'(e_pe));
                chk(rx_irq == e_irq, "R9", "rx_irq", 16'(rx_irq), 16'(e_irq));
                chk(err_overrun == e_ovr, "R10", "err_overrun", 16'(err_overrun), 16'(e_ovr));
            end
            if (ack_req) begin
                rd_ack  = 1'b1;
                ack_req = 0;
                ack_on  = 1;
            end
            phase = (phase + 1) % 4;
            tick  = (phase == 0);
            if ((phase == 3) && (!active || (gtick - ustart >= 4))) begin
                if (unit_q.size() > 0) begin
                    u      = unit_q.pop_front();
                    rxd    = u.lvl;
                    active = 1;
                    ustart = gtick;
                    if (u.first) begin
                        pend_e    = frm_q.pop_front();
                        pend      = 1;
                        pend_tick = gtick + 10 + 16 * (pend_e.nb + 1);
                    end
                end else begin
                    rxd    = 1'b1;
                    active = 0;
                end
            end
            if (cyc > 150000 && !finished) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (unit_q.size() != 0 || active || pend);
        repeat (3) @(negedge clk);
    endtask

    task automatic push_units(input logic lvl, input int n, input bit mark);
        for (int k = 0; k < n; k++) begin
            unit_t u;
            u.lvl   = lvl;
            u.first = mark && (k == 0);
            unit_q.push_back(u);
        end
    endtask

    task automatic send(input logic [8:0] p, input logic [1:0] ls, input bit pen,
                        input bit podd, input bit badp, input bit stopl,
                        input int extra_low, input string tag, input bit ack);
        int   nd;
        bit   pon;
        logic ones, pbit;
        exp_t e;
        wait_idle();
        len_sel = ls;
        par_en  = pen;
        par_odd = podd;
        nd   = (ls == 2'b00) ? 7 : (ls == 2'b10) ? 9 : 8;
        pon  = pen && (ls != 2'b10);
        ones = 1'b0;
        for (int i = 0; i < nd; i++) ones = ones ^ p[i];
        pbit = ones ^ podd ^ badp;
        e.data = p[7:0];
        e.mask = (nd == 7) ? 8'h7F : 8'hFF;
        e.b9   = (nd == 9) ? p[8] : (pon ? pbit : 1'b0);
        e.fe   = !stopl;
        e.pe   = pon && badp;
        e.nb   = nd + (pon ? 1 : 0);
        e.tag  = tag;
        frm_q.push_back(e);
        push_units(1'b0, 4, 1);
        for (int i = 0; i < nd; i++) push_units(p[i], 4, 0);
        if (pon) push_units(pbit, 4, 0);
        push_units(stopl, 4, 0);
        push_units(1'b0, extra_low, 0);
        push_units(1'b1, 2, 0);
        wait_idle();
        if (ack) begin
            ack_req = 1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(rx_data == 8'h00 && rx_bit9 == 0, "R1", "data after reset", 16'({rx_bit9, rx_data}), 16'h0);
        chk({rx_irq, err_frame, err_parity, err_overrun} == 4'b0, "R1", "flags after reset",
            16'({rx_irq, err_frame, err_parity, err_overrun}), 16'h0);

        send(9'h0A5, 2'b01, 0, 0, 0, 1, 0, "R2", 1);
        send(9'h03C, 2'b01, 0, 0, 0, 1, 0, "R2", 1);
        send(9'h0D5, 2'b00, 0, 0, 0, 1, 0, "R4", 1);   // R4: bit 7 masked
        send(9'h00F, 2'b01, 1, 0, 0, 1, 0, "R6", 1);   // even, parity 0
        send(9'h007, 2'b01, 1, 0, 0, 1, 0, "R6", 1);   // even, parity 1
        send(9'h0C3, 2'b01, 1, 1, 1, 1, 0, "R7", 1);   // odd, wrong parity
        send(9'h031, 2'b00, 1, 1, 0, 1, 0, "R7", 1);   // odd, 7 bits, correct
        send(9'h1A5, 2'b10, 1, 0, 0, 1, 0, "R5", 1);   // par_en ignored
        send(9'h05A, 2'b10, 0, 1, 0, 1, 0, "R5", 1);
        send(9'h0E7, 2'b01, 0, 0, 0, 1, 0, "R11", 1);  // R11: bit9 back to 0

        // R3: short low pulse must vanish
        wait_idle();
        push_units(1'b0, 1, 0);
        push_units(1'b1, 6, 0);
        wait_idle();
        chk(rx_irq == 1'b0, "R3", "irq after glitch", 16'(rx_irq), 16'h0);
        chk(rx_data == 8'hE7, "R3", "data after glitch", 16'(rx_data), 16'h00E7);

        // R8: low stop bit, line kept low, then a clean frame
        send(9'h096, 2'b01, 0, 0, 0, 0, 2, "R8", 1);
        send(9'h069, 2'b01, 0, 0, 0, 1, 0, "R8", 0);
        chk(rx_data == 8'h69 && err_frame == 0, "R8", "frame after recovery", 16'({err_frame, rx_data}), 16'h0069);

        // R10: second frame without acknowledge
        send(9'h011, 2'b01, 0, 0, 0, 1, 0, "R10", 0);
        chk(err_overrun == 1'b1, "R10", "overrun set", 16'(err_overrun), 16'h1);
        ack_req = 1;
        repeat (3) @(negedge clk);
        chk(err_overrun == 1'b0 && rx_irq == 1'b0, "R10", "ack clears", 16'({err_overrun, rx_irq}), 16'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule